// File: doc/BRIEF.md
# Sample Rate Tracking Servo Loop

This block follows the timing relationship between two sample strobes: one marks input samples and the other marks output samples. The two strobes are asynchronous to each other, and both are sampled in one fast system clock. A free-running counter advances once per input sample. Its value serves as the write address of the sample buffer and also as a coarse ramp that locates each output instant among the input samples.

Timing one output strobe directly against the system clock is too coarse to give a fine interpolation phase. The loop therefore captures the ramp at every output strobe and takes the difference between successive captures. That difference counts how many input samples passed during one output period. A first-order recursive average of this integer count gives the input/output rate ratio with a 20-bit fraction.

An accumulator holds a buffer read address plus a 20-bit phase. It advances by the averaged ratio at each output strobe, and it is pulled toward the captured ramp by a small proportional correction. The read address, the phase and the ratio are handed to a convolution engine. The ratio is what the engine uses to scale its data and its filter length. A lock flag reports when the phase error has stayed small for a long run of output strobes.

Top module: `srt_servo_loop`

## Requirements
- R1: While rst_ni is low, the following outputs are all zero: wr_addr_o, rd_addr_o, phase_o, ratio_o, lock_o and vld_o.
- R2: Each strobe input is a level, and its rising edge marks a sample. The edge is found when the level is high at clock edge n and was low at edge n-1. The block acts on it at clock edge n+2, and the result is visible after that edge.
- R3: wr_addr_o is an ADDR_W-bit input sample count. It rises by one for each input strobe and wraps modulo 2^ADDR_W.
- R4: Each output strobe captures the ramp as the value of wr_addr_o before any increment at the same edge, so a coincident input strobe is not yet counted. The first output strobe after reset only records the capture. The next one seeds two values: the ratio becomes the raw difference × 2^20, and the accumulator becomes the captured ramp × 2^20.
- R5: On every later output strobe, the raw difference is the current capture minus the previous one, modulo 2^ADDR_W. The ratio is updated as ratio + floor((raw × 2^20 − ratio) / 256).
- R6: On a tracking strobe, the prediction is accumulator + old ratio. The error is ramp × 2^20 − prediction, taken as a signed value modulo 2^(ADDR_W+20). The new accumulator is prediction + floor(error / 64). rd_addr_o carries the upper ADDR_W bits of the accumulator and phase_o carries its lower 20 bits.
- R7: vld_o is high for exactly one cycle after each seeding or tracking update, and at no other time.
- R8: lock_o rises after LOCK_N consecutive tracking updates whose absolute error is below LOCK_THR. An update whose error is at or above LOCK_THR restarts the count.
- R9: While lock_o is high, an update whose absolute error exceeds 4 × LOCK_THR clears lock_o. The next output strobe then seeds the loop again as in R4.
- R10: With steady strobes, ratio_o settles near (output period / input period) × 2^20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_stb_i | input | 1 | Input sample strobe level, asynchronous |
| out_stb_i | input | 1 | Output sample strobe level, asynchronous |
| wr_addr_o | output | ADDR_W | Input sample counter / buffer write address |
| rd_addr_o | output | ADDR_W | Integer buffer start address for the convolution |
| phase_o | output | FRAC_W | Fractional phase between input samples |
| ratio_o | output | ADDR_W+FRAC_W | Averaged input/output rate ratio, 20 fractional bits |
| lock_o | output | 1 | Loop lock flag |
| vld_o | output | 1 | One-cycle pulse when rd_addr_o, phase_o and ratio_o are updated |

## Verification
Every result is due at a fixed clock edge, two edges after the strobe level is first seen high at a clock edge. Both the counter and the tracking outputs change on that edge. The vld_o pulse covers the cycle that follows it. The bench reference model keeps its own three-deep history of the sampled strobe levels, so its events fall on the same edges as the design's. Every output is compared at the falling clock edge of each cycle. The directed checks for the latency and for seeding wait the exact number of falling edges. The settling checks on lock and ratio come after thousands of strobes, or a few hundred cycles after a rate step.

// File: rtl/srt_pkg.sv
package srt_pkg;
  typedef enum logic [1:0] {
    LP_EMPTY = 2'd0,
    LP_SEED  = 2'd1,
    LP_TRACK = 2'd2
  } loop_st_e;
endpackage

// File: rtl/srt_strobe_sync.sv
module srt_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic evt_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], lvl_i};
  end

  // rising edge after the synchroniser
  assign evt_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/srt_ratio_avg.sv
module srt_ratio_avg #(
  parameter int ADDR_W = 9,
  parameter int FRAC_W = 20,
  parameter int AVG_SH = 8,
  localparam int W     = ADDR_W + FRAC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              seed_i,
  input  logic              trk_i,
  input  logic [ADDR_W-1:0] raw_i,
  output logic [W-1:0]      ratio_o
);
  logic [W-1:0]        tgt;
  logic signed [W:0]   diff;
  logic signed [W:0]   step;

  assign tgt  = {raw_i, {FRAC_W{1'b0}}};
  assign diff = $signed({1'b0, tgt}) - $signed({1'b0, ratio_o});
  assign step = diff >>> AVG_SH;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ratio_o <= '0;
    else if (seed_i) ratio_o <= tgt;
    else if (trk_i)  ratio_o <= ratio_o + step[W-1:0];
  end
endmodule

// File: rtl/srt_phase_trk.sv
module srt_phase_trk #(
  parameter int ADDR_W = 9,
  parameter int FRAC_W = 20,
  parameter int P_SH   = 6,
  localparam int W     = ADDR_W + FRAC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              seed_i,
  input  logic              trk_i,
  input  logic [ADDR_W-1:0] ramp_i,
  input  logic [W-1:0]      ratio_i,
  output logic [W-1:0]      acc_o,
  output logic [W-1:0]      err_abs_o
);
  logic [W-1:0]        ramp_fx;
  logic [W-1:0]        pred;
  logic [W-1:0]        err;
  logic signed [W-1:0] corr;

  assign ramp_fx   = {ramp_i, {FRAC_W{1'b0}}};
  assign pred      = acc_o + ratio_i;
  assign err       = ramp_fx - pred;
  assign corr      = $signed(err) >>> P_SH;
  assign err_abs_o = err[W-1] ? (~err + W'(1)) : err;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_o <= '0;
    else if (seed_i) acc_o <= ramp_fx;
    else if (trk_i)  acc_o <= pred + $unsigned(corr);
  end
endmodule

// File: rtl/srt_lock_det.sv
module srt_lock_det #(
  parameter int          W        = 29,
  parameter int          LOCK_N   = 1024,
  parameter int unsigned LOCK_THR = 32'd1572864,
  localparam int CNT_W = $clog2(LOCK_N + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         trk_i,
  input  logic [W-1:0] err_abs_i,
  output logic         lock_o,
  output logic         drop_o
);
  localparam logic [W+1:0] THR  = (W+2)'(LOCK_THR);
  localparam logic [W+1:0] THR4 = THR << 2;

  logic [CNT_W-1:0] cnt_q;
  logic [W+1:0]     mag;

  assign mag    = {2'b00, err_abs_i};
  assign drop_o = trk_i & lock_o & (mag > THR4);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      lock_o <= 1'b0;
    end else if (trk_i) begin
      if (drop_o) begin
        cnt_q  <= '0;
        lock_o <= 1'b0;
      end else if (mag < THR) begin
        if (cnt_q != CNT_W'(LOCK_N)) cnt_q <= cnt_q + CNT_W'(1);
        if (cnt_q == CNT_W'(LOCK_N - 1)) lock_o <= 1'b1;
      end else begin
        cnt_q <= '0;
      end
    end
  end
endmodule

// File: rtl/srt_servo_loop.sv
module srt_servo_loop #(
  parameter int          ADDR_W      = 9,
  parameter int          FRAC_W      = 20,
  parameter int          AVG_SH      = 8,
  parameter int          P_SH        = 6,
  parameter int          LOCK_N      = 1024,
  parameter int unsigned LOCK_THR    = 32'd1572864,
  parameter int          SYNC_STAGES = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     in_stb_i,
  input  logic                     out_stb_i,
  output logic [ADDR_W-1:0]        wr_addr_o,
  output logic [ADDR_W-1:0]        rd_addr_o,
  output logic [FRAC_W-1:0]        phase_o,
  output logic [ADDR_W+FRAC_W-1:0] ratio_o,
  output logic                     lock_o,
  output logic                     vld_o
);
  import srt_pkg::*;
  localparam int W = ADDR_W + FRAC_W;

  logic [1:0]        lvl, evt;
  logic              in_evt, out_evt;
  logic [ADDR_W-1:0] ramp_q, last_q, raw;
  loop_st_e          st_q;
  logic              seed, trk, drop;
  logic [W-1:0]      acc, err_abs;

  assign lvl = {out_stb_i, in_stb_i};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    srt_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .lvl_i  (lvl[g]),
      .evt_o  (evt[g])
    );
  end

  assign in_evt  = evt[0];
  assign out_evt = evt[1];
  assign raw     = ramp_q - last_q;
  assign seed    = out_evt & (st_q == LP_SEED);
  assign trk     = out_evt & (st_q == LP_TRACK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ramp_q <= '0;
      last_q <= '0;
      st_q   <= LP_EMPTY;
      vld_o  <= 1'b0;
    end else begin
      if (in_evt) ramp_q <= ramp_q + ADDR_W'(1);
      vld_o <= seed | trk;
      if (out_evt) begin
        last_q <= ramp_q;
        unique case (st_q)
          LP_EMPTY: st_q <= LP_SEED;
          LP_SEED:  st_q <= LP_TRACK;
          default:  st_q <= drop ? LP_SEED : LP_TRACK;
        endcase
      end
    end
  end

  srt_ratio_avg #(.ADDR_W(ADDR_W), .FRAC_W(FRAC_W), .AVG_SH(AVG_SH)) u_ratio (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .seed_i  (seed),
    .trk_i   (trk),
    .raw_i   (raw),
    .ratio_o (ratio_o)
  );

  srt_phase_trk #(.ADDR_W(ADDR_W), .FRAC_W(FRAC_W), .P_SH(P_SH)) u_phase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .seed_i    (seed),
    .trk_i     (trk),
    .ramp_i    (ramp_q),
    .ratio_i   (ratio_o),
    .acc_o     (acc),
    .err_abs_o (err_abs)
  );

  srt_lock_det #(.W(W), .LOCK_N(LOCK_N), .LOCK_THR(LOCK_THR)) u_lock (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .trk_i     (trk),
    .err_abs_i (err_abs),
    .lock_o    (lock_o),
    .drop_o    (drop)
  );

  assign wr_addr_o = ramp_q;
  assign rd_addr_o = acc[W-1:FRAC_W];
  assign phase_o   = acc[FRAC_W-1:0];
endmodule

// File: rtl/srt_servo_chk.sv
module srt_servo_chk #(
  parameter int ADDR_W = 9,
  parameter int FRAC_W = 20
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [ADDR_W-1:0]        wr_addr_o,
  input logic [ADDR_W-1:0]        rd_addr_o,
  input logic [FRAC_W-1:0]        phase_o,
  input logic [ADDR_W+FRAC_W-1:0] ratio_o,
  input logic                     lock_o,
  input logic                     vld_o
);
  AST_WR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(wr_addr_o) |-> wr_addr_o == $past(wr_addr_o) + ADDR_W'(1)); // R3
  AST_VLD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |=> !vld_o); // R7
  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_o |-> ($stable(rd_addr_o) && $stable(phase_o))); // R6
  AST_RATIO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_o |-> $stable(ratio_o)); // R5
  AST_LOCK_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> vld_o); // R8
  AST_LOCK_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lock_o) |-> vld_o); // R9
endmodule

bind srt_servo_loop srt_servo_chk #(.ADDR_W(ADDR_W), .FRAC_W(FRAC_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_addr_o (wr_addr_o),
  .rd_addr_o (rd_addr_o),
  .phase_o   (phase_o),
  .ratio_o   (ratio_o),
  .lock_o    (lock_o),
  .vld_o     (vld_o)
);

// File: tb/tb_srt_servo_loop.sv
module tb_srt_servo_loop;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 9;
  localparam int FW = 20;
  localparam int WW = AW + FW;
  localparam longint MA = (64'd1 << AW) - 1;
  localparam longint MF = (64'd1 << FW) - 1;
  localparam longint MW = (64'd1 << WW) - 1;
  localparam longint HALF = 64'd1 << (WW - 1);
  localparam longint THR = 64'd1572864;
  localparam int LN = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_lvl = 1'b0;
  logic out_lvl = 1'b0;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [FW-1:0] phase;
  logic [WW-1:0] ratio;
  logic lock, vld;

  int n_vec = 0;
  int n_bad = 0;
  bit chk_en = 1'b0;
  bit done = 1'b0;
  bit gen_en = 1'b0;
  int pin = 10, pout = 13, ci = 0, co = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  srt_servo_loop dut (
    .clk_i(clk), .rst_ni(rst_n), .in_stb_i(in_lvl), .out_stb_i(out_lvl),
    .wr_addr_o(wr_addr), .rd_addr_o(rd_addr), .phase_o(phase),
    .ratio_o(ratio), .lock_o(lock), .vld_o(vld)
  );

  // reference model state
  bit a1i, a2i, a3i, a1o, a2o, a3o;
  longint m_wr, m_last, m_ratio, m_acc;
  int m_st, m_cnt;
  bit m_lock, m_vld;

  always @(posedge clk) begin
    bit ei, eo;
    longint ramp, raw, p, e, es, ab;
    if (!rst_n) begin
      {a1i, a2i, a3i, a1o, a2o, a3o} = '0;
      m_wr = 0; m_last = 0; m_ratio = 0; m_acc = 0;
      m_st = 0; m_cnt = 0; m_lock = 0; m_vld = 0;
    end else begin
      ei = a2i & !a3i;
      eo = a2o & !a3o;
      a3i = a2i; a2i = a1i; a1i = in_lvl;
      a3o = a2o; a2o = a1o; a1o = out_lvl;
      ramp = m_wr;
      m_vld = 0;
      if (eo) begin
        raw = (ramp - m_last) & MA;
        if (m_st == 0) begin
          m_st = 1;
        end else if (m_st == 1) begin
          m_ratio = raw << FW;
          m_acc = ramp << FW;
          m_st = 2;
          m_vld = 1;
        end else begin
          p = (m_acc + m_ratio) & MW;
          e = ((ramp << FW) - p) & MW;
          es = (e >= HALF) ? e - (64'd1 << WW) : e;
          ab = (es < 0) ? -es : es;
          m_ratio = (m_ratio + (((raw << FW) - m_ratio) >>> 8)) & MW;
          m_acc = (p + (es >>> 6)) & MW;
          if (m_lock && ab > 4 * THR) begin
            m_lock = 0; m_cnt = 0; m_st = 1;
          end else if (ab < THR) begin
            if (m_cnt != LN) m_cnt++;
            if (m_cnt == LN) m_lock = 1;
          end else begin
            m_cnt = 0;
          end
          m_vld = 1;
        end
        m_last = ramp;
      end
      if (ei) m_wr = (m_wr + 1) & MA;
    end
  end

  task automatic check(string tag, longint act, longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_rng(string tag, longint act, longint lo, longint hi);
    n_vec++;
    if (act < lo || act > hi) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (chk_en) begin
      string t;
      t = rst_n ? "" : " R1";
      n_vec++;
      if ({wr_addr, rd_addr, phase, ratio, lock, vld} !==
          {AW'(m_wr), AW'(m_acc >> FW), FW'(m_acc & MF), WW'(m_ratio), m_lock, m_vld}) begin
        n_vec--;
        check({"R3 wr_addr", t}, longint'(wr_addr), m_wr);
        check({"R6 rd_addr", t}, longint'(rd_addr), (m_acc >> FW));
        check({"R6 phase", t}, longint'(phase), (m_acc & MF));
        check({"R5 ratio", t}, longint'(ratio), m_ratio);
        check({"R8 lock", t}, longint'(lock), longint'(m_lock));
        check({"R7 vld", t}, longint'(vld), longint'(m_vld));
      end
    end
  end

  // periodic strobe generator
  always @(negedge clk) begin
    if (gen_en) begin
      ci = (ci + 1 >= pin) ? 0 : ci + 1;
      co = (co + 1 >= pout) ? 0 : co + 1;
      in_lvl = (ci < pin / 2);
      out_lvl = (co < pout / 2);
    end
  end

  task automatic in_pulse();
    in_lvl = 1'b1; @(negedge clk); @(negedge clk);
    in_lvl = 1'b0; @(negedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    chk_en = 1'b1;
    @(negedge clk);
    check("R1 reset wr_addr", longint'(wr_addr), 0);
    check("R1 reset ratio", longint'(ratio), 0);
    check("R1 reset lock/vld", longint'({lock, vld}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R2: edge seen at posedge n acts at posedge n+2
    in_lvl = 1'b1;
    @(negedge clk);
    check("R2 wr_addr after n", longint'(wr_addr), 0);
    @(negedge clk);
    check("R2 wr_addr after n+1", longint'(wr_addr), 0);
    @(negedge clk);
    check("R2 wr_addr after n+2", longint'(wr_addr), 1);
    in_lvl = 1'b0;
    repeat (2) @(negedge clk);
    // R4: first output strobe only captures
    out_lvl = 1'b1; @(negedge clk); @(negedge clk);
    out_lvl = 1'b0; @(negedge clk);
    check("R4 first capture no vld", longint'(vld), 0);
    @(negedge clk);
    repeat (3) in_pulse();
    // R4: coincident strobes seed with the pre-increment ramp
    in_lvl = 1'b1; out_lvl = 1'b1;
    repeat (3) @(negedge clk);
    check("R4 seed rd_addr", longint'(rd_addr), 4);
    check("R4 seed phase", longint'(phase), 0);
    check("R4 seed ratio", longint'(ratio), 3 << FW);
    check("R4 seed vld", longint'(vld), 1);
    check("R3 coincident wr_addr", longint'(wr_addr), 5);
    in_lvl = 1'b0; out_lvl = 1'b0;
    repeat (4) @(negedge clk);
    // steady rates 10:13
    pin = 10; pout = 13; ci = 0; co = 0;
    gen_en = 1'b1;
    repeat (39000) @(negedge clk);
    check("R8 locked at 13/10", longint'(lock), 1);
    check_rng("R10 ratio 13/10", longint'(ratio), 1336000, 1390000);
    // rate step to 27:10
    pout = 27;
    repeat (300) @(negedge clk);
    check("R9 lock lost after rate step", longint'(lock), 0);
    repeat (81000) @(negedge clk);
    check("R8 relocked at 27/10", longint'(lock), 1);
    check_rng("R10 ratio 27/10", longint'(ratio), 2774000, 2888000);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule